// File: doc/BRIEF.md
# Boundary-Scan Self-Test Pattern Engine

This block drives the sixteen data cells of the boundary register of an octal bidirectional transceiver during built-in self-test. Each data cell has a shift stage, which updates on the rising test clock. It also has a shadow latch, which copies the shift stage on the following falling test clock. The shadow latches on the output side drive the output pins. Those on the input side feed the internal logic. The direction cell and the output-enable cell are inputs to this block, and the block never changes them.

A two-bit opcode selects one of four operations:

- sample the input pins and toggle the outputs,
- 16-bit pseudo-random pattern generation,
- 16-bit parallel signature compaction,
- a split mode, in which an 8-bit signature register and an 8-bit generator run side by side.

The operation advances on each rising edge while `run_en` is high. The surrounding test-access logic asserts `run_en` while it is idling with the run-test instruction selected. When `run_en` is low, a seed can be loaded in parallel into the shift stages. When there is no seed load either, every cell holds its value.

The engine is a small state machine. Its state records which operation the last rising edge performed. States: `ST_HOLD` (nothing done), `ST_LOAD` (seed loaded), `ST_SAMP_TGL`, `ST_PRPG16`, `ST_PSA16`, `ST_MIX8`. The next state is decided on every rising edge. If `run_en` is high, the opcode picks the state (00 gives `ST_SAMP_TGL`, 01 gives `ST_PRPG16`, 10 gives `ST_PSA16`, 11 gives `ST_MIX8`). Otherwise `seed_load` gives `ST_LOAD`, and anything else gives `ST_HOLD`. Any state can move to any other state on any edge. The shadow latches copy on a falling edge only when the state is not `ST_HOLD`.

Top module: `bscan_pattern_engine`

## Requirements
- R1: While `rst_n` is low, `shift_q` and `shadow_q` are all zero and the state is `ST_HOLD`.
- R2: On a rising edge with `run_en` low and `seed_load` low, `shift_q` keeps its value, and on the following falling edge `shadow_q` keeps its value.
- R3: On a rising edge with `run_en` low and `seed_load` high, `shift_q` takes `seed_val`. `run_en` high takes precedence over `seed_load`.
- R4: Opcode 00: the input-side cells capture the input-side pins, with pin k going to cell k of its group, and the output-side cells invert.
- R5: Opcode 01: `shift_q` becomes {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R6: Opcode 01 with an all-zero `shift_q` leaves `shift_q` all zero.
- R7: From any nonzero seed, 65535 steps of opcode 01 return `shift_q` to the seed.
- R8: Opcode 10: `shift_q` becomes {s[14:0], s[15]^s[13]^s[12]^s[10]} XOR {pin_b, pin_a}.
- R9: Opcode 11: the 8-bit input-side group g becomes {g[6:0], g[7]^g[5]^g[4]^g[3]} XOR the input-side pins. The output-side group h becomes {h[6:0], h[7]^h[5]^h[4]^h[3]}.
- R10: `dir_cell`=1 makes port A (cells 7:0) the input side and port B (cells 15:8) the output side. `dir_cell`=0 swaps the two.
- R11: On the falling edge after a rising edge in any state other than `ST_HOLD`, `shadow_q` takes `shift_q`. `out_pins` shows the output-side group of `shadow_q` and `core_in` shows the input-side group.
- R12: `out_drive` equals `oe_cell`, where 1 means the outputs drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Idle state with the run-test instruction selected |
| opcode | input | 2 | Test operation select |
| seed_load | input | 1 | Parallel load of `seed_val` while not running |
| seed_val | input | 16 | Seed or scan value for the shift stages |
| dir_cell | input | 1 | Direction cell value (1: A is the input side) |
| oe_cell | input | 1 | Output-enable cell value |
| pin_a | input | 8 | Port A pin levels |
| pin_b | input | 8 | Port B pin levels |
| shift_q | output | 16 | Shift-stage contents of the data cells |
| shadow_q | output | 16 | Shadow-latch contents of the data cells |
| out_pins | output | 8 | Values driven onto the output-side port |
| out_drive | output | 1 | Output drivers enabled |
| core_in | output | 8 | Values fed to the internal logic |

## Verification
Each new `shift_q` value is due on the first rising edge that sees the stimulus. The shadow latch, `out_pins` and `core_in` follow on the very next falling edge. `out_drive` follows `oe_cell` with no delay. The bench drives inputs 1 ns after a falling edge so that they are stable at the next rising edge. It compares `shift_q` 1 ns after that rising edge, and the latch-side outputs 1 ns after the following falling edge. It does this against a reference model that steps once per edge. The long generator run is checked on every step and then against the seed after 65535 steps.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    localparam int GRP_W  = 8;
    localparam int CELL_W = 2 * GRP_W;

    // feedback tap masks: bit i set means cell i feeds the XOR
    localparam logic [CELL_W-1:0] TAPS_WIDE   = 16'hB400; // cells 15,13,12,10
    localparam logic [GRP_W-1:0]  TAPS_NARROW = 8'hB8;    // cells 7,5,4,3

    localparam logic [1:0] OP_SAMP_TGL = 2'b00;
    localparam logic [1:0] OP_PRPG16   = 2'b01;
    localparam logic [1:0] OP_PSA16    = 2'b10;
    localparam logic [1:0] OP_MIX8     = 2'b11;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_LOAD,
        ST_SAMP_TGL,
        ST_PRPG16,
        ST_PSA16,
        ST_MIX8
    } eng_st_e;

endpackage

// File: rtl/lfsr_next.sv
module lfsr_next #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    TAPS = 16'hB400
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] inj,
    output logic [W-1:0] nxt
);
    logic [W-1:0] tapped;
    logic         fb;

    always_comb begin
        tapped = cur & TAPS;
        fb     = ^tapped;
        nxt    = {cur[W-2:0], fb} ^ inj;
    end

endmodule

// File: rtl/bsc_step_unit.sv
module bsc_step_unit
    import bsc_pkg::*;
#(
    parameter int GW = GRP_W,
    localparam int CW = 2 * GW
) (
    input  eng_st_e        st,
    input  logic           a_is_in,
    input  logic [CW-1:0]  cur,
    input  logic [CW-1:0]  seed_val,
    input  logic [GW-1:0]  pin_a,
    input  logic [GW-1:0]  pin_b,
    output logic [CW-1:0]  nxt
);
    logic [GW-1:0] in_grp, out_grp, in_pins;
    logic [CW-1:0] wide_gen, wide_sig, all_pins;
    logic [GW-1:0] nar_sig, nar_gen;
    logic [GW-1:0] tgl_in, tgl_out, new_in, new_out;

    always_comb begin
        in_grp   = a_is_in ? cur[GW-1:0]  : cur[CW-1:GW];
        out_grp  = a_is_in ? cur[CW-1:GW] : cur[GW-1:0];
        in_pins  = a_is_in ? pin_a : pin_b;
        all_pins = {pin_b, pin_a};
    end

    lfsr_next #(.W(CW), .TAPS(TAPS_WIDE)) u_wide_gen (
        .cur(cur), .inj({CW{1'b0}}), .nxt(wide_gen)
    );

    lfsr_next #(.W(CW), .TAPS(TAPS_WIDE)) u_wide_sig (
        .cur(cur), .inj(all_pins), .nxt(wide_sig)
    );

    lfsr_next #(.W(GW), .TAPS(TAPS_NARROW)) u_nar_sig (
        .cur(in_grp), .inj(in_pins), .nxt(nar_sig)
    );

    lfsr_next #(.W(GW), .TAPS(TAPS_NARROW)) u_nar_gen (
        .cur(out_grp), .inj({GW{1'b0}}), .nxt(nar_gen)
    );

    // per-cell sample and toggle
    for (genvar k = 0; k < GW; k++) begin : g_tgl
        assign tgl_in[k]  = in_pins[k];
        assign tgl_out[k] = ~out_grp[k];
    end

    always_comb begin
        new_in  = in_grp;
        new_out = out_grp;
        unique case (st)
            ST_SAMP_TGL: begin new_in = tgl_in;  new_out = tgl_out; end
            ST_MIX8:     begin new_in = nar_sig; new_out = nar_gen; end
            default:     begin new_in = in_grp;  new_out = out_grp; end
        endcase
    end

    always_comb begin
        unique case (st)
            ST_HOLD:     nxt = cur;
            ST_LOAD:     nxt = seed_val;
            ST_PRPG16:   nxt = wide_gen;
            ST_PSA16:    nxt = wide_sig;
            ST_SAMP_TGL,
            ST_MIX8:     nxt = a_is_in ? {new_out, new_in} : {new_in, new_out};
            default:     nxt = cur;
        endcase
    end

endmodule

// File: rtl/bsc_shadow.sv
module bsc_shadow #(
    parameter int W = 16
) (
    input  logic         tck,
    input  logic         rst_n,
    input  logic         copy_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n)       q <= '0;
        else if (copy_en) q <= d;
    end

    // R2: with no copy request, the latch keeps its value across a falling edge
    p_latch_hold_r2: assert property (@(negedge tck) disable iff (!rst_n)
        !copy_en |=> $stable(q));

endmodule

// File: rtl/bscan_pattern_engine.sv
module bscan_pattern_engine
    import bsc_pkg::*;
#(
    parameter int GW = GRP_W,
    localparam int CW = 2 * GW
) (
    input  logic          tck,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [1:0]    opcode,
    input  logic          seed_load,
    input  logic [CW-1:0] seed_val,
    input  logic          dir_cell,
    input  logic          oe_cell,
    input  logic [GW-1:0] pin_a,
    input  logic [GW-1:0] pin_b,
    output logic [CW-1:0] shift_q,
    output logic [CW-1:0] shadow_q,
    output logic [GW-1:0] out_pins,
    output logic          out_drive,
    output logic [GW-1:0] core_in
);
    eng_st_e       cur_st, nxt_st;
    logic [CW-1:0] shift_nxt;

    // next-state decode
    always_comb begin
        nxt_st = ST_HOLD;
        if (run_en) begin
            unique case (opcode)
                OP_SAMP_TGL: nxt_st = ST_SAMP_TGL;
                OP_PRPG16:   nxt_st = ST_PRPG16;
                OP_PSA16:    nxt_st = ST_PSA16;
                OP_MIX8:     nxt_st = ST_MIX8;
                default:     nxt_st = ST_HOLD;
            endcase
        end else if (seed_load) begin
            nxt_st = ST_LOAD;
        end
    end

    // state register
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) cur_st <= ST_HOLD;
        else        cur_st <= nxt_st;
    end

    bsc_step_unit #(.GW(GW)) u_step (
        .st       (nxt_st),
        .a_is_in  (dir_cell),
        .cur      (shift_q),
        .seed_val (seed_val),
        .pin_a    (pin_a),
        .pin_b    (pin_b),
        .nxt      (shift_nxt)
    );

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= shift_nxt;
    end

    bsc_shadow #(.W(CW)) u_shadow (
        .tck     (tck),
        .rst_n   (rst_n),
        .copy_en (cur_st != ST_HOLD),
        .d       (shift_q),
        .q       (shadow_q)
    );

    // outputs
    always_comb begin
        out_drive = oe_cell;
        out_pins  = dir_cell ? shadow_q[CW-1:GW] : shadow_q[GW-1:0];
        core_in   = dir_cell ? shadow_q[GW-1:0]  : shadow_q[CW-1:GW];
    end

    p_hold_r2: assert property (@(posedge tck) disable iff (!rst_n)
        (!run_en && !seed_load) |=> $stable(shift_q));

    p_load_r3: assert property (@(posedge tck) disable iff (!rst_n)
        (!run_en && seed_load) |=> shift_q == $past(seed_val));

    p_toggle_r4: assert property (@(posedge tck) disable iff (!rst_n)
        (run_en && opcode == OP_SAMP_TGL && dir_cell)
        |=> shift_q[CW-1:GW] == ~$past(shift_q[CW-1:GW]));

    p_zero_seed_r6: assert property (@(posedge tck) disable iff (!rst_n)
        (run_en && opcode == OP_PRPG16 && shift_q == '0) |=> shift_q == '0);

    p_shadow_copy_r11: assert property (@(posedge tck) disable iff (!rst_n)
        (cur_st != ST_HOLD) |-> shadow_q == shift_q);

endmodule

// File: tb/sim_bscan_pattern_engine.sv
module sim_bscan_pattern_engine;
    logic        tck = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [1:0]  opcode = 2'b00;
    logic        seed_load = 1'b0;
    logic [15:0] seed_val = '0;
    logic        dir_cell = 1'b1;
    logic        oe_cell = 1'b0;
    logic [7:0]  pin_a = '0;
    logic [7:0]  pin_b = '0;
    logic [15:0] shift_q, shadow_q;
    logic [7:0]  out_pins, core_in;
    logic        out_drive;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    logic [15:0] m_sh = '0;
    logic [15:0] m_lat = '0;
    bit          m_act = 0;
    int unsigned rng = 32'h1234_5677;

    always #5 tck = ~tck;

    bscan_pattern_engine u0 (
        .tck(tck), .rst_n(rst_n), .run_en(run_en), .opcode(opcode),
        .seed_load(seed_load), .seed_val(seed_val), .dir_cell(dir_cell),
        .oe_cell(oe_cell), .pin_a(pin_a), .pin_b(pin_b),
        .shift_q(shift_q), .shadow_q(shadow_q), .out_pins(out_pins),
        .out_drive(out_drive), .core_in(core_in)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // one LFSR step of width w; returns value confined to w bits
    function automatic logic [15:0] m_lfsr(input int w, input logic [15:0] s);
        int t[4];
        int fb;
        if (w == 16) t = '{15, 13, 12, 10};
        else         t = '{7, 5, 4, 3};
        fb = 0;
        foreach (t[i]) fb = fb ^ int'(s[t[i]]);
        return ((s << 1) | 16'(fb)) & 16'((32'd1 << w) - 1);
    endfunction

    function automatic logic [15:0] m_join(input logic d, input logic [7:0] ing, input logic [7:0] outg);
        return d ? {outg, ing} : {ing, outg};
    endfunction

    function automatic int unsigned next_rng(input int unsigned r);
        int unsigned x = r;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic step(input string req, input bit run, input logic [1:0] op,
                        input bit ld, input logic [15:0] sd, input bit dir,
                        input bit oe, input logic [7:0] pa, input logic [7:0] pb);
        logic [7:0] ig, og, ip;
        run_en = run; opcode = op; seed_load = ld; seed_val = sd;
        dir_cell = dir; oe_cell = oe; pin_a = pa; pin_b = pb;
        @(posedge tck); #1;
        ig = dir ? m_sh[7:0] : m_sh[15:8];
        og = dir ? m_sh[15:8] : m_sh[7:0];
        ip = dir ? pa : pb;
        m_act = 1;
        if (run) begin
            case (op)
                2'b00: m_sh = m_join(dir, ip, ~og);
                2'b01: m_sh = m_lfsr(16, m_sh);
                2'b10: m_sh = m_lfsr(16, m_sh) ^ {pb, pa};
                default: m_sh = m_join(dir, m_lfsr(8, {8'h0, ig})[7:0] ^ ip,
                                       m_lfsr(8, {8'h0, og})[7:0]);
            endcase
        end else if (ld) begin
            m_sh = sd;
        end else begin
            m_act = 0;
        end
        check({req, " shift"}, {16'h0, shift_q}, {16'h0, m_sh});
        @(negedge tck); #1;
        if (m_act) m_lat = m_sh;
        check({req, " R11 latch/pins"}, {shadow_q, out_pins, core_in},
              {m_lat, dir ? m_lat[15:8] : m_lat[7:0], dir ? m_lat[7:0] : m_lat[15:8]});
        check({req, " R12 drive"}, {31'h0, out_drive}, {31'h0, oe});
    endtask

    task automatic rnd_steps(input string req, input int n, input bit run,
                             input logic [1:0] op, input bit dir);
        for (int i = 0; i < n; i++) begin
            rng = next_rng(rng);
            step(req, run, op, 1'b0, 16'h0, dir, rng[20], rng[7:0], rng[15:8]);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] seed;
        repeat (3) @(posedge tck);
        #2;
        // R1: reset state
        check("R1 shift", {16'h0, shift_q}, 32'h0);
        check("R1 latch", {16'h0, shadow_q}, 32'h0);
        @(negedge tck); #1;
        rst_n = 1'b1;

        step("R3 load", 0, 2'b00, 1, 16'hACE1, 1, 1, 8'h00, 8'h00);
        rnd_steps("R2 hold", 4, 0, 2'b00, 1);
        step("R3 run beats load", 1, 2'b01, 1, 16'h0000, 1, 0, 8'h00, 8'h00);

        // R4 / R10: sample-toggle both directions
        rnd_steps("R4 R10 toggle A-in", 6, 1, 2'b00, 1);
        rnd_steps("R4 R10 toggle B-in", 6, 1, 2'b00, 0);
        rnd_steps("R2 hold after toggle", 2, 0, 2'b00, 0);

        // R8: wide signature
        step("R8 psa known", 1, 2'b10, 0, 16'h0, 1, 1, 8'h5A, 8'hC3);
        rnd_steps("R8 psa", 10, 1, 2'b10, 1);

        // R9 / R10: split mode both directions
        step("R3 load", 0, 2'b00, 1, 16'h8001, 1, 1, 8'h0, 8'h0);
        rnd_steps("R9 R10 mix A-in", 10, 1, 2'b11, 1);
        rnd_steps("R9 R10 mix B-in", 10, 1, 2'b11, 0);

        // R6: zero seed stays zero
        step("R3 load zero", 0, 2'b00, 1, 16'h0000, 1, 0, 8'h0, 8'h0);
        for (int i = 0; i < 8; i++) step("R6 zero seed", 1, 2'b01, 0, 16'h0, 1, 0, 8'hFF, 8'hFF);
        check("R6 zero seed final", {16'h0, shift_q}, 32'h0);

        // R5 / R7: full generator period
        seed = 16'h1D2B;
        step("R3 load seed", 0, 2'b00, 1, seed, 1, 1, 8'h0, 8'h0);
        for (int i = 0; i < 65535; i++) begin
            step("R5 prpg", 1, 2'b01, 0, 16'h0, i[0], 1, i[7:0], i[15:8]);
        end
        check("R7 period returns to seed", {16'h0, shift_q}, {16'h0, seed});

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule